// File: doc/BRIEF.md
# Ring Channel Event Counter

This block counts occurrences of one selected event in a ring interconnect agent. Every cycle the agent presents an event strobe, an 8-bit event code and a flag saying which outbound ring channel the event is headed for: the extended channel or the normal channel. Software-held configuration chooses the code to count and sets a 2-bit channel filter. A matching event adds one to a wide counter, which wraps and leaves a sticky overflow flag behind.

The channel filter applies only to transmit-request event codes in the window 0x47 to 0x59, inclusive at both ends. For every other code the filter setting is ignored, and each matching event is counted whatever its channel. Two of the filter encodings select the same behaviour, so either of them may be written.

Top module: `ring_chan_evcnt`

## Requirements
- R1: After a synchronous reset, `count` reads zero and `overflow` reads 0.
- R2: An event increments `count` by one only when `ev_valid` is 1 and `ev_code` equals `cfg_code`. The new value is visible after the next rising clock edge. Any other event leaves `count` unchanged.
- R3: For an event code between 0x47 and 0x59 inclusive, filter value 2'b00 counts matching events on either channel.
- R4: For an event code in the window, filter value 2'b11 counts only events with `ev_ext` = 1 (extended channel).
- R5: For an event code in the window, filter value 2'b01 behaves exactly like 2'b11.
- R6: For an event code in the window, filter value 2'b10 counts only events with `ev_ext` = 0 (normal channel).
- R7: For event codes below 0x47 or above 0x59, every matching event is counted, whatever the filter value and `ev_ext`.
- R8: While `cnt_en` is 0, `count` holds its value.
- R9: `cnt_clr` = 1 sets `count` to zero and `overflow` to 0 at the next edge, even when a counted event arrives in the same cycle.
- R10: An increment from all ones wraps `count` to zero and sets `overflow`. `overflow` stays at 1 until a clear or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is present this cycle |
| ev_code | input | 8 | Code of the present event |
| ev_ext | input | 1 | 1: event heads for the extended channel, 0: the normal channel |
| cfg_code | input | 8 | Event code selected for counting |
| cfg_chan | input | 2 | Channel filter (00 any, 01/11 extended, 10 normal) |
| cnt_en | input | 1 | Counting enable |
| cnt_clr | input | 1 | Synchronous clear of count and overflow |
| count | output | CNT_W | Event count |
| overflow | output | 1 | Sticky wrap indication |

## Verification
The only state in the block is the count register and the overflow bit. If an event is qualified wrongly, `count` is off by one at the first clock edge after that event. The error then stays in `count` until a clear. If the overflow bit is wrong, it appears at the edge where `count` wraps, or at the edge after an event that should have kept it set. The bench therefore compares `count` with an arithmetic total after every short burst of events, so any fault shows within a few cycles of the event that caused it.

// File: rtl/rce_pkg.sv
package rce_pkg;

    localparam int EV_W = 8;

    // Window of event codes for which the channel filter is honoured
    localparam logic [EV_W-1:0] FILT_LO = 8'h47;
    localparam logic [EV_W-1:0] FILT_HI = 8'h59;

    typedef enum logic [1:0] {
        CH_ANY   = 2'b00,
        CH_EXT_A = 2'b01,
        CH_NORM  = 2'b10,
        CH_EXT   = 2'b11
    } chan_mode_e;

    typedef struct packed {
        logic            valid;
        logic [EV_W-1:0] code;
        logic            ext;
    } ev_t;

    function automatic logic code_filtered(input logic [EV_W-1:0] c);
        return (c >= FILT_LO) && (c <= FILT_HI);
    endfunction

    function automatic logic chan_ok(input chan_mode_e m, input logic ext);
        logic ok;
        case (m)
            CH_ANY:          ok = 1'b1;
            CH_NORM:         ok = ~ext;
            CH_EXT, CH_EXT_A: ok = ext;
            default:         ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/rce_qualify.sv
module rce_qualify
    import rce_pkg::*;
(
    input  ev_t             ev,
    input  logic [EV_W-1:0] sel_code,
    input  chan_mode_e      mode,
    output logic            hit
);
    logic code_eq;
    logic in_win;
    logic chan_pass;

    always_comb begin
        code_eq   = ev.valid && (ev.code == sel_code);
        in_win    = code_filtered(ev.code);
        // Outside the window the channel is not looked at
        chan_pass = in_win ? chan_ok(mode, ev.ext) : 1'b1;
        hit       = code_eq && chan_pass;
    end
endmodule

// File: rtl/rce_counter.sv
module rce_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             inc,
    output logic [CNT_W-1:0] value,
    output logic             wrapped
);
    logic at_max;

    always_comb at_max = &value;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            value   <= '0;
            wrapped <= 1'b0;
        end else if (en && inc) begin
            value <= value + 1'b1;
            if (at_max) begin
                wrapped <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ring_chan_evcnt.sv
module ring_chan_evcnt
    import rce_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic [7:0]       ev_code,
    input  logic             ev_ext,
    input  logic [7:0]       cfg_code,
    input  logic [1:0]       cfg_chan,
    input  logic             cnt_en,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    ev_t        ev_in;
    chan_mode_e mode;
    logic       hit;

    always_comb begin
        ev_in.valid = ev_valid;
        ev_in.code  = ev_code;
        ev_in.ext   = ev_ext;
        mode        = chan_mode_e'(cfg_chan);
    end

    rce_qualify u_qual (
        .ev       (ev_in),
        .sel_code (cfg_code),
        .mode     (mode),
        .hit      (hit)
    );

    rce_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .en      (cnt_en),
        .inc     (hit),
        .value   (count),
        .wrapped (overflow)
    );
endmodule

// File: rtl/rce_checker.sv
module rce_checker #(
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_valid,
    input logic [7:0]       ev_code,
    input logic             ev_ext,
    input logic [7:0]       cfg_code,
    input logic [1:0]       cfg_chan,
    input logic             cnt_en,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] count,
    input logic             overflow
);
    logic win;
    always_comb win = (ev_code >= 8'h47) && (ev_code <= 8'h59);

    // R9
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (count == '0) && !overflow);

    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && !cnt_en) |=> $stable(count));

    // R2
    a_r2_no_valid: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && !ev_valid) |=> $stable(count));

    // R2
    a_r2_mismatch: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && ev_code != cfg_code) |=> $stable(count));

    // R4 and R5: extended-only filters drop normal-channel events
    a_r4_ext_only: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && win && cfg_chan[0] && !ev_ext) |=> $stable(count));

    // R6
    a_r6_norm_only: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && win && cfg_chan == 2'b10 && ev_ext) |=> $stable(count));

    // R7
    a_r7_out_window: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && cnt_en && ev_valid && ev_code == cfg_code && !win)
        |=> count == CNT_W'($past(count) + 1'b1));

    // R10
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (overflow && !cnt_clr) |=> overflow);

    // R10
    a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && cnt_en && ev_valid && ev_code == cfg_code && !win && (&count))
        |=> overflow && (count == '0));
endmodule

bind ring_chan_evcnt rce_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_ring_chan_evcnt.sv
`timescale 1ns/1ps
module tb_ring_chan_evcnt;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ev_valid = 1'b0;
    logic [7:0]       ev_code = '0;
    logic             ev_ext = 1'b0;
    logic [7:0]       cfg_code = '0;
    logic [1:0]       cfg_chan = '0;
    logic             cnt_en = 1'b0;
    logic             cnt_clr = 1'b0;
    logic [CNT_W-1:0] count;
    logic             overflow;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    ring_chan_evcnt #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code),
        .ev_ext(ev_ext), .cfg_code(cfg_code), .cfg_chan(cfg_chan),
        .cnt_en(cnt_en), .cnt_clr(cnt_clr), .count(count), .overflow(overflow)
    );

    task automatic check(input string tag, input int exp_cnt, input bit exp_ovf);
        checks++;
        if (count !== CNT_W'(exp_cnt) || overflow !== exp_ovf) begin
            errors++;
            $display("FAIL %s: count=%0d overflow=%0b expected count=%0d overflow=%0b",
                     tag, count, overflow, exp_cnt, exp_ovf);
        end
    endtask

    // Independent model of the qualification rule
    function automatic bit counts_it(input int code, input int filt, input bit ext);
        bit inw;
        inw = (code >= 'h47) && (code <= 'h59);
        if (!inw || filt == 0) return 1'b1;
        if (filt == 2) return !ext;
        return ext;
    endfunction

    task automatic do_clear();
        @(negedge clk);
        cnt_clr  = 1'b1;
        ev_valid = 1'b0;
        @(negedge clk);
        cnt_clr  = 1'b0;
    endtask

    task automatic event_on(input int code, input bit ext);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_code  = 8'(code);
        ev_ext   = ext;
    endtask

    task automatic idle();
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", 0, 1'b0);
        cnt_en = 1'b1;

        // Sweep codes around the filter window and at the extremes, all filters
        for (int k = 0; k < 35; k++) begin
            int c;
            c = (k < 33) ? ('h40 + k) : ((k == 33) ? 'h00 : 'hFF);
            for (int f = 0; f < 4; f++) begin
                int exp_n;
                string tag;
                exp_n = 0;
                cfg_code = 8'(c);
                cfg_chan = 2'(f);
                do_clear();
                for (int v = 0; v < 2; v++)
                    for (int x = 0; x < 2; x++)
                        for (int a = 0; a < 2; a++) begin
                            int code;
                            code = a ? (c ^ 1) : c;
                            @(negedge clk);
                            ev_valid = v[0];
                            ev_code  = 8'(code);
                            ev_ext   = x[0];
                            if (v == 1 && a == 0 && counts_it(c, f, x[0])) exp_n++;
                        end
                idle();
                if (c < 'h47 || c > 'h59) tag = "R7 filter ignored outside window";
                else if (f == 0) tag = "R3 any channel";
                else if (f == 3) tag = "R4 extended only";
                else if (f == 1) tag = "R5 alias of extended";
                else tag = "R6 normal only";
                check($sformatf("%s code=%0h filt=%0d", tag, c, f), exp_n, 1'b0);
            end
        end

        // R2: only the selected code counts, and only with the strobe
        cfg_code = 8'h50;
        cfg_chan = 2'b00;
        do_clear();
        for (int e = 0; e < 256; e++) event_on(e, 1'b1);
        idle();
        check("R2 full code sweep with strobe", 1, 1'b0);
        for (int e = 0; e < 256; e++) begin
            @(negedge clk);
            ev_valid = 1'b0;
            ev_code  = 8'(e);
        end
        idle();
        check("R2 full code sweep without strobe", 1, 1'b0);

        // R8: enable low holds the count
        cnt_en = 1'b0;
        for (int i = 0; i < 10; i++) event_on('h50, 1'b0);
        idle();
        check("R8 hold while disabled", 1, 1'b0);
        cnt_en = 1'b1;
        event_on('h50, 1'b0);
        idle();
        check("R8 counts again once enabled", 2, 1'b0);

        // R10: wrap at all ones, sticky overflow
        cfg_code = 8'h20;
        cfg_chan = 2'b10;
        do_clear();
        for (int i = 0; i < (1 << CNT_W) - 1; i++) event_on('h20, 1'b1);
        idle();
        check("R10 at all ones before wrap", (1 << CNT_W) - 1, 1'b0);
        event_on('h20, 1'b1);
        idle();
        check("R10 wrap to zero sets overflow", 0, 1'b1);
        event_on('h20, 1'b0);
        idle();
        repeat (3) @(negedge clk);
        check("R10 overflow sticky", 1, 1'b1);

        // R9: clear wins over a simultaneous counted event
        @(negedge clk);
        cnt_clr  = 1'b1;
        ev_valid = 1'b1;
        ev_code  = 8'h20;
        @(negedge clk);
        cnt_clr  = 1'b0;
        ev_valid = 1'b0;
        check("R9 clear over event", 0, 1'b0);

        // R1: reset mid-run
        event_on('h20, 1'b1);
        idle();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset after counting", 0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule